// File: doc/BRIEF.md
# Chained Block-Read Request Engine

This block moves a large transfer as a chain of block-read requests with no software in the loop. Software writes a start address, a total byte count, a largest request size and a response time limit. It then writes the start code into a two-bit control field during the same register write. The engine issues one read-request descriptor and waits for the matching response. When that response arrives, it issues the next request from the advanced address. It stops when the whole count has been fetched or when something goes wrong.

When it stops, the engine pulses an end interrupt for one cycle and latches a status code. The code stays readable until the next accepted start. Only one request is outstanding at any time. Each request carries a small wrapping tag, and the returning response must echo that tag. Moving the data itself and sending the packets on the link are handled outside the block.

The state machine has four states:
- **IDLE**: waiting for a start.
- **ISSUE**: presenting a request until the receiver takes it.
- **WAIT**: holding response-ready and counting cycles.
- **END**: one cycle that raises the interrupt.

Its transitions are:
- **start**: IDLE to ISSUE.
- **quick-finish**: IDLE to END, when the configuration is bad or the length is zero.
- **handoff**: ISSUE to WAIT.
- **chain**: WAIT to ISSUE.
- **stop**: WAIT to END, on the last response, an error or a timeout.
- **return**: END to IDLE.

Top module: `blkrd_chain_engine`

## Requirements
- R1: A start is accepted only when `cfg_wr` is high, `cfg_ctl` equals 2'b10, and both `cfg_rx_en` and `cfg_chain_mode` are 1. Any other write leaves `busy` and `req_valid` at 0 and leaves `status` unchanged.
- R2: Each request length equals the smaller of the largest request size and the remaining byte count. The first request address is the start address.
- R3: After each good response, the address advances by the length just granted. The tag starts at 0 on every start and increments by one per request, wrapping modulo 2^TAG_W.
- R4: A new request is presented only after the response to the previous one. `req_valid` and `rsp_ready` are never high in the same cycle.
- R5: While `req_valid` is high and `req_ready` is low, the request is held: valid, address and length stay unchanged.
- R6: On stopping, `end_irq` is high for exactly one cycle, with `busy` still high and `status` already valid; `busy` then drops. A good final response gives status 1. A zero total length gives status 1 with no request issued.
- R7: A response with a non-zero rcode ends the operation with status 2. This check takes priority over the tag check.
- R8: A response whose tag differs from the outstanding tag ends the operation with status 3.
- R9: If no response arrives within `cfg_timeout` cycles in WAIT, the operation ends with status 4. A response arriving in the last of those cycles is still accepted.
- R10: A zero largest request size or a zero time limit ends the operation at once with status 5, with no request issued.
- R11: A start write while the engine is busy is ignored. The running chain continues from its own address.
- R12: After reset, `busy`, `req_valid`, `rsp_ready` and `end_irq` are 0 and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rx_en | input | 1 | Receive path enable |
| cfg_chain_mode | input | 1 | Selects the chained request mode |
| cfg_wr | input | 1 | Register write strobe for the control word |
| cfg_ctl | input | 2 | Control field; 2'b10 requests a start |
| cfg_start_addr | input | ADDR_W | First byte address of the transfer |
| cfg_total_len | input | LEN_W | Total bytes to fetch |
| cfg_max_chunk | input | LEN_W | Largest bytes per request |
| cfg_timeout | input | TMO_W | Response time limit in cycles |
| req_valid | output | 1 | Request descriptor valid |
| req_ready | input | 1 | Request receiver ready |
| req_addr | output | ADDR_W | Request address |
| req_len | output | LEN_W | Request length in bytes |
| req_tag | output | TAG_W | Request tag |
| rsp_valid | input | 1 | Response present |
| rsp_ready | output | 1 | Engine waiting for a response |
| rsp_rcode | input | RC_W | Response code, zero for success |
| rsp_tag | input | TAG_W | Tag echoed by the response |
| busy | output | 1 | Operation in progress, END cycle included |
| end_irq | output | 1 | One-cycle end interrupt |
| status | output | 3 | Latched result code |

## Verification
An accepted start write shows up one edge later: `req_valid` is high with the first descriptor, or `end_irq` is high for the zero-length and bad-configuration cases. A response taken at an edge puts the next descriptor, or the END cycle, on the ports at that same edge. A timeout lands on the `cfg_timeout`-th WAIT edge with no response. The bench drives every input at the falling edge and samples the outputs at the following falling edge. Each check therefore reads the state exactly one register stage after its stimulus. The wait and hold lengths are counted in falling edges, so the expected addresses, lengths, tags and codes follow from the sweep arithmetic.

// File: rtl/blkrd_pkg.sv
package blkrd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_END   = 2'd3
    } chain_state_t;

    localparam logic [2:0] STS_NONE    = 3'd0;
    localparam logic [2:0] STS_DONE    = 3'd1;
    localparam logic [2:0] STS_RCODE   = 3'd2;
    localparam logic [2:0] STS_TAGERR  = 3'd3;
    localparam logic [2:0] STS_TIMEOUT = 3'd4;
    localparam logic [2:0] STS_BADCFG  = 3'd5;

    localparam logic [1:0] CTL_START = 2'b10;

endpackage

// File: rtl/blkrd_chunk_sizer.sv
// Picks the length of the next request: largest allowed size or what is left.
module blkrd_chunk_sizer #(
    parameter int LEN_W = 16
) (
    input  logic [LEN_W-1:0] remaining,
    input  logic [LEN_W-1:0] max_chunk,
    output logic [LEN_W-1:0] grant
);
    always_comb begin
        if (max_chunk < remaining) grant = max_chunk;
        else                       grant = remaining;
    end
endmodule

// File: rtl/blkrd_resp_judge.sv
// Classifies an incoming response; rcode failure outranks tag mismatch.
module blkrd_resp_judge #(
    parameter int TAG_W = 4,
    parameter int RC_W  = 4
) (
    input  logic             armed,
    input  logic             rsp_valid,
    input  logic [RC_W-1:0]  rsp_rcode,
    input  logic [TAG_W-1:0] rsp_tag,
    input  logic [TAG_W-1:0] exp_tag,
    output logic             take,
    output logic             good,
    output logic             bad_rcode,
    output logic             bad_tag
);
    logic rc_fail;
    logic tag_fail;

    assign rc_fail  = (rsp_rcode != '0);
    assign tag_fail = (rsp_tag != exp_tag);

    always_comb begin
        take      = armed && rsp_valid;
        bad_rcode = take && rc_fail;
        bad_tag   = take && !rc_fail && tag_fail;
        good      = take && !rc_fail && !tag_fail;
    end
endmodule

// File: rtl/blkrd_wait_timer.sv
// Counts response-wait cycles; flags expiry on the limit-th idle cycle.
module blkrd_wait_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt;
    logic [TMO_W-1:0] last_idx;

    assign last_idx = limit - TMO_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (run)   cnt <= cnt + TMO_W'(1);
    end

    assign expired = run && (cnt == last_idx);
endmodule

// File: rtl/blkrd_chain_engine.sv
module blkrd_chain_engine
    import blkrd_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int LEN_W  = 16,
    parameter int TMO_W  = 16,
    parameter int TAG_W  = 4,
    parameter int RC_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_rx_en,
    input  logic              cfg_chain_mode,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_ctl,
    input  logic [ADDR_W-1:0] cfg_start_addr,
    input  logic [LEN_W-1:0]  cfg_total_len,
    input  logic [LEN_W-1:0]  cfg_max_chunk,
    input  logic [TMO_W-1:0]  cfg_timeout,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_len,
    output logic [TAG_W-1:0]  req_tag,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [RC_W-1:0]   rsp_rcode,
    input  logic [TAG_W-1:0]  rsp_tag,
    output logic              busy,
    output logic              end_irq,
    output logic [2:0]        status
);

    chain_state_t state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  remain_q;
    logic [LEN_W-1:0]  chunk_q;
    logic [LEN_W-1:0]  granted_q;
    logic [TMO_W-1:0]  limit_q;
    logic [TAG_W-1:0]  tag_q;
    logic [2:0]        status_q;
    logic [2:0]        end_code;

    logic start_hit;
    logic cfg_bad;
    logic handoff;
    logic [LEN_W-1:0] grant;
    logic rsp_take, rsp_good, rsp_bad_rc, rsp_bad_tag;
    logic tmo_expired;
    logic last_piece;

    assign start_hit = cfg_wr && (cfg_ctl == CTL_START) && cfg_rx_en
                    && cfg_chain_mode && (state_q == ST_IDLE);
    assign cfg_bad   = (cfg_max_chunk == '0) || (cfg_timeout == '0);
    assign handoff   = (state_q == ST_ISSUE) && req_ready;
    assign last_piece = (remain_q == granted_q);

    blkrd_chunk_sizer #(.LEN_W(LEN_W)) u_sizer (
        .remaining (remain_q),
        .max_chunk (chunk_q),
        .grant     (grant)
    );

    blkrd_resp_judge #(.TAG_W(TAG_W), .RC_W(RC_W)) u_judge (
        .armed     (state_q == ST_WAIT),
        .rsp_valid (rsp_valid),
        .rsp_rcode (rsp_rcode),
        .rsp_tag   (rsp_tag),
        .exp_tag   (tag_q),
        .take      (rsp_take),
        .good      (rsp_good),
        .bad_rcode (rsp_bad_rc),
        .bad_tag   (rsp_bad_tag)
    );

    blkrd_wait_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q != ST_WAIT),
        .run     ((state_q == ST_WAIT) && !rsp_valid),
        .limit   (limit_q),
        .expired (tmo_expired)
    );

    // Next state and the code to latch when entering END.
    always_comb begin
        state_d  = state_q;
        end_code = STS_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (start_hit) begin
                    if (cfg_bad) begin
                        state_d  = ST_END;
                        end_code = STS_BADCFG;
                    end else if (cfg_total_len == '0) begin
                        state_d  = ST_END;
                        end_code = STS_DONE;
                    end else begin
                        state_d  = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (req_ready) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_bad_rc) begin
                    state_d  = ST_END;
                    end_code = STS_RCODE;
                end else if (rsp_bad_tag) begin
                    state_d  = ST_END;
                    end_code = STS_TAGERR;
                end else if (rsp_good) begin
                    if (last_piece) begin
                        state_d  = ST_END;
                        end_code = STS_DONE;
                    end else begin
                        state_d  = ST_ISSUE;
                    end
                end else if (tmo_expired) begin
                    state_d  = ST_END;
                    end_code = STS_TIMEOUT;
                end
            end
            ST_END: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transfer bookkeeping registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            remain_q  <= '0;
            chunk_q   <= '0;
            granted_q <= '0;
            limit_q   <= '0;
            tag_q     <= '0;
            status_q  <= STS_NONE;
        end else begin
            if (start_hit) begin
                addr_q   <= cfg_start_addr;
                remain_q <= cfg_total_len;
                chunk_q  <= cfg_max_chunk;
                limit_q  <= cfg_timeout;
                tag_q    <= '0;
            end
            if (handoff) granted_q <= grant;
            if (rsp_good) begin
                addr_q   <= addr_q + ADDR_W'(granted_q);
                remain_q <= remain_q - granted_q;
                tag_q    <= tag_q + TAG_W'(1);
            end
            if ((state_d == ST_END) && (state_q != ST_END))
                status_q <= end_code;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        req_valid = (state_q == ST_ISSUE);
        rsp_ready = (state_q == ST_WAIT);
        end_irq   = (state_q == ST_END);
        busy      = (state_q != ST_IDLE);
        req_addr  = addr_q;
        req_len   = grant;
        req_tag   = tag_q;
        status    = status_q;
    end

endmodule

// File: rtl/blkrd_chain_checker.sv
module blkrd_chain_checker #(
    parameter int ADDR_W = 48,
    parameter int LEN_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [LEN_W-1:0]  req_len,
    input logic              rsp_ready,
    input logic              busy,
    input logic              end_irq,
    input logic [2:0]        status
);

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len));

    assert_one_outstanding_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && rsp_ready));

    assert_len_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != '0));

    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        end_irq |=> !end_irq && !busy);

    assert_irq_has_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        end_irq |-> (status != 3'd0) && busy);

    assert_busy_drop_after_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(end_irq));

endmodule

bind blkrd_chain_engine blkrd_chain_checker #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
) u_chain_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .rsp_ready (rsp_ready),
    .busy      (busy),
    .end_irq   (end_irq),
    .status    (status)
);

// File: tb/blkrd_chain_engine_test.sv
module blkrd_chain_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_rx_en = 1'b0, cfg_chain_mode = 1'b0, cfg_wr = 1'b0;
    logic [1:0]  cfg_ctl = 2'b00;
    logic [47:0] cfg_start_addr = '0;
    logic [15:0] cfg_total_len = '0, cfg_max_chunk = '0, cfg_timeout = '0;
    logic        req_valid, req_ready = 1'b0;
    logic [47:0] req_addr;
    logic [15:0] req_len;
    logic [3:0]  req_tag;
    logic        rsp_valid = 1'b0, rsp_ready;
    logic [3:0]  rsp_rcode = '0, rsp_tag = '0;
    logic        busy, end_irq;
    logic [2:0]  status;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    blkrd_chain_engine uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_rx_en(cfg_rx_en), .cfg_chain_mode(cfg_chain_mode),
        .cfg_wr(cfg_wr), .cfg_ctl(cfg_ctl),
        .cfg_start_addr(cfg_start_addr), .cfg_total_len(cfg_total_len),
        .cfg_max_chunk(cfg_max_chunk), .cfg_timeout(cfg_timeout),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_rcode(rsp_rcode), .rsp_tag(rsp_tag),
        .busy(busy), .end_irq(end_irq), .status(status)
    );

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Drives one control write; returns at the falling edge after it.
    task automatic do_start(input logic [47:0] a, input int t, input int c, input int to,
                            input logic rx, input logic md, input logic [1:0] ctl);
        @(negedge clk);
        cfg_start_addr = a; cfg_total_len = 16'(t); cfg_max_chunk = 16'(c);
        cfg_timeout = 16'(to); cfg_rx_en = rx; cfg_chain_mode = md;
        cfg_ctl = ctl; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_ctl = 2'b00;
    endtask

    // Expects a request now, holds it for `hold` cycles, then accepts it.
    task automatic serve_req(input longint ea, input int el, input int et, input int hold);
        chk("R4", "req_valid", req_valid, 1);
        chk("R2", "req_len", req_len, el);
        chk("R3", "req_addr", req_addr, ea);
        chk("R3", "req_tag", req_tag, et);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk("R5", "held req", {req_valid, req_len, req_addr}, {1'b1, 16'(el), 48'(ea)});
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        chk("R4", "wait without request", {req_valid, rsp_ready}, 2'b01);
    endtask

    task automatic respond(input int dly, input logic [3:0] tg, input logic [3:0] rc);
        repeat (dly) @(negedge clk);
        rsp_valid = 1'b1; rsp_tag = tg; rsp_rcode = rc;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_rcode = '0;
    endtask

    task automatic expect_end(input int code, input string rq);
        chk(rq, "irq/busy/status", {end_irq, busy, status}, {1'b1, 1'b1, 3'(code)});
        @(negedge clk);
        chk(rq, "after irq", {end_irq, busy, req_valid, status}, {1'b0, 1'b0, 1'b0, 3'(code)});
    endtask

    task automatic run_ok(input longint a, input int t, input int c, input int to);
        int rem = t;
        int k = 0;
        longint off = 0;
        do_start(48'(a), t, c, to, 1'b1, 1'b1, 2'b10);
        if (t == 0) begin
            expect_end(1, "R6");
            return;
        end
        while (rem > 0) begin
            int g = (c < rem) ? c : rem;
            serve_req(a + off, g, k % 16, k % 2);
            respond(k % 3, 4'(k), 4'h0);
            rem -= g; off += g; k++;
        end
        expect_end(1, "R6");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R12", "reset outputs", {busy, req_valid, rsp_ready, end_irq, status}, 7'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "after release", {busy, req_valid, end_irq, status}, 6'b0);

        // R1: gating of the start write.
        do_start(48'h40, 8, 4, 8, 1'b0, 1'b1, 2'b10);
        chk("R1", "rx_en off", {busy, req_valid, status}, 5'b0);
        do_start(48'h40, 8, 4, 8, 1'b1, 1'b0, 2'b10);
        chk("R1", "mode off", {busy, req_valid, status}, 5'b0);
        do_start(48'h40, 8, 4, 8, 1'b1, 1'b1, 2'b01);
        chk("R1", "wrong code", {busy, req_valid, status}, 5'b0);

        // R2/R3/R6 sweep of length and request size.
        for (int t = 0; t <= 24; t++)
            for (int c = 1; c <= 5; c++)
                run_ok(48'h1000 + 48'(t * 64), t, c, 8);

        // R3: tag wraps past 15.
        run_ok(48'hFFFF_FFF0, 20, 1, 4);

        // R7: bad rcode, also with a wrong tag (rcode wins).
        do_start(48'h200, 8, 4, 8, 1'b1, 1'b1, 2'b10);
        serve_req(48'h200, 4, 0, 0);
        respond(0, 4'h0, 4'h6);
        expect_end(2, "R7");
        do_start(48'h200, 8, 4, 8, 1'b1, 1'b1, 2'b10);
        serve_req(48'h200, 4, 0, 0);
        respond(1, 4'h5, 4'h1);
        expect_end(2, "R7");

        // R8: tag mismatch on the second response.
        do_start(48'h300, 12, 4, 8, 1'b1, 1'b1, 2'b10);
        serve_req(48'h300, 4, 0, 0);
        respond(0, 4'h0, 4'h0);
        serve_req(48'h304, 4, 1, 0);
        respond(0, 4'h0, 4'h0);
        expect_end(3, "R8");

        // R9: response in the final allowed cycle, then a timeout.
        do_start(48'h400, 4, 4, 5, 1'b1, 1'b1, 2'b10);
        serve_req(48'h400, 4, 0, 0);
        respond(4, 4'h0, 4'h0);
        expect_end(1, "R9");
        do_start(48'h400, 4, 4, 5, 1'b1, 1'b1, 2'b10);
        serve_req(48'h400, 4, 0, 0);
        repeat (4) @(negedge clk);
        chk("R9", "still waiting", {rsp_ready, end_irq}, 2'b10);
        @(negedge clk);
        expect_end(4, "R9");

        // R10: bad configuration.
        do_start(48'h500, 8, 0, 8, 1'b1, 1'b1, 2'b10);
        expect_end(5, "R10");
        do_start(48'h500, 8, 4, 0, 1'b1, 1'b1, 2'b10);
        expect_end(5, "R10");

        // R11: start write during WAIT is ignored.
        do_start(48'h600, 8, 4, 8, 1'b1, 1'b1, 2'b10);
        serve_req(48'h600, 4, 0, 0);
        do_start(48'h900, 2, 1, 8, 1'b1, 1'b1, 2'b10);
        chk("R11", "still waiting", {busy, rsp_ready}, 2'b11);
        respond(0, 4'h0, 4'h0);
        serve_req(48'h604, 4, 1, 0);
        respond(0, 4'h1, 4'h0);
        expect_end(1, "R11");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule